// File: doc/BRIEF.md
# Condition Code and Branch Decision Unit

This block pairs an 8-bit adder with the condition code register that records its outcome and with an evaluator that decides conditional branches. On each operation step it forms A + M, with the stored carry as an optional carry-in, and registers the sum. The same step updates the five arithmetic flags: half-carry, negative, zero, overflow and carry. Every instruction carries a two-bit policy for each of those flags. The policy leaves the flag alone, clears it, sets it, or loads it from the computed result. This lets one datapath serve adds, flag-clearing instructions, index loads and instructions that touch no flags at all.

The three control bits of the register (stop-disable, external-interrupt mask, interrupt mask) never follow arithmetic. They change only through an explicit whole-register load. A separate strobe asks for a branch decision on a four-bit condition code. The decision uses the flags as stored before that clock edge, and it comes back as a registered one-cycle pulse. The conditions cover the simple flag tests and the full set of signed and unsigned comparisons.

Top module: `ccr_branch_unit`

## Requirements
- R1: While `rst` is high, and after it falls until the first operation, `result` is 0, `ccr` is 8'hD0 (stop-disable, external mask and interrupt mask set, all arithmetic flags clear) and `br_take` is 0.
- R2: When `op_valid` is high at a rising edge, `result` takes (A + M + cin) mod 256 from that edge on, where cin is the stored carry (`ccr[0]`) if `use_carry` is high and 0 otherwise.
- R3: A computed carry is the carry out of bit 7. A computed overflow is the carry into bit 7 XOR the carry out of bit 7, which is two's-complement overflow.
- R4: A computed half-carry is the carry out of bit 3. A computed negative is bit 7 of the sum, and a computed zero is 1 exactly when the sum is 0. For example, 8'hAA + 8'hBC gives 8'h66 with H=1, N=0, Z=0, V=1, C=1.
- R5: `flag_pol` holds one 2-bit policy per flag: [1:0] carry, [3:2] overflow, [5:4] zero, [7:6] negative, [9:8] half-carry. The codes are 0 keep, 1 clear, 2 set, 3 computed. Each flag follows its own field independently of the others.
- R6: When `op_valid` is low, the operands, `use_carry` and `flag_pol` have no effect: `result` and the arithmetic flags keep their values.
- R7: `ccr` is laid out as bit 7 stop-disable, 6 external mask, 5 H, 4 interrupt mask, 3 N, 2 Z, 1 V, 0 C. Bits 7, 6 and 4 change only when `ccr_load` is high, which copies all of `ccr_wdata` into `ccr` at that edge. A load takes priority over a flag update at the same edge.
- R8: `br_take` is registered. After an edge where `br_eval` is high, it shows the decision for `br_sel` made on the `ccr` value held before that edge. After an edge where `br_eval` is low, it is 0.
- R9: Simple conditions by `br_sel`: 0 always, 1 never, 4 C=0, 5 C=1, 6 Z=0, 7 Z=1, 8 V=0, 9 V=1, 10 N=0, 11 N=1.
- R10: Signed conditions by `br_sel`: 12 greater-or-equal when N^V=0, 13 less-than when N^V=1, 14 greater-than when Z=0 and N^V=0, 15 less-or-equal when Z=1 or N^V=1.
- R11: Unsigned conditions by `br_sel`: 2 higher when C=0 and Z=0, 3 lower-or-same when C=1 or Z=1. Higher-or-same and lower are codes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the add and flag update at this edge |
| opnd_a | input | 8 | Accumulator operand |
| opnd_m | input | 8 | Memory operand |
| use_carry | input | 1 | Add the stored carry as carry-in |
| flag_pol | input | 10 | Per-flag update policy |
| ccr_load | input | 1 | Load the whole condition code register |
| ccr_wdata | input | 8 | Value for an explicit load |
| br_eval | input | 1 | Request a branch decision |
| br_sel | input | 4 | Branch condition code |
| result | output | 8 | Registered sum |
| ccr | output | 8 | Condition code register |
| br_take | output | 1 | Registered branch decision |

## Verification
A wrong flag in the register is visible on `ccr` one edge after the operation that wrote it. It also spreads a cycle later: a wrong stored carry turns into a wrong sum on the next add-with-carry, and a wrong N, Z, V or C flips one or more branch decisions. Those decisions appear on `br_take` one edge after the request. So the bench walks every combination of the four tested flags through all sixteen conditions. It also checks that a decision and an update on the same edge use the old flags. A corrupted control bit stays wrong until the next explicit load, and `ccr` shows it on every cycle.

// File: rtl/ccbu_pkg.sv
package ccbu_pkg;
  typedef enum logic [1:0] {
    POL_KEEP = 2'd0,
    POL_CLR  = 2'd1,
    POL_SET  = 2'd2,
    POL_CALC = 2'd3
  } flag_pol_e;

  localparam int CCR_W      = 8;
  localparam int NUM_AFLAGS = 5;
  localparam int POL_W      = 2 * NUM_AFLAGS;

  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_I = 4;
  localparam int BIT_H = 5;
  localparam int BIT_X = 6;
  localparam int BIT_S = 7;

  // arithmetic flags in policy-field order: c=0, v=1, z=2, n=3, h=4
  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } aflags_t;

  function automatic int af_pos(input int k);
    case (k)
      0: af_pos = BIT_C;
      1: af_pos = BIT_V;
      2: af_pos = BIT_Z;
      3: af_pos = BIT_N;
      default: af_pos = BIT_H;
    endcase
  endfunction
endpackage

// File: rtl/ccbu_adder.sv
module ccbu_adder
  import ccbu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  output logic [W-1:0] sum,
  output aflags_t      flags
);
  localparam int HB = W / 2;

  logic [W:0]    full_sum;
  logic [HB:0]   low_sum;
  logic [W-1:0]  below_msb;
  logic          carry_into_msb;

  always_comb begin
    full_sum       = {1'b0, a} + {1'b0, m} + {{W{1'b0}}, cin};
    low_sum        = {1'b0, a[HB-1:0]} + {1'b0, m[HB-1:0]} + {{HB{1'b0}}, cin};
    below_msb      = {1'b0, a[W-2:0]} + {1'b0, m[W-2:0]} + {{(W-1){1'b0}}, cin};
    carry_into_msb = below_msb[W-1];
    sum            = full_sum[W-1:0];
    flags.c        = full_sum[W];
    flags.v        = carry_into_msb ^ full_sum[W];
    flags.h        = low_sum[HB];
    flags.n        = full_sum[W-1];
    flags.z        = (full_sum[W-1:0] == '0);
  end
endmodule

// File: rtl/ccbu_flag_reg.sv
module ccbu_flag_reg
  import ccbu_pkg::*;
#(
  parameter logic [CCR_W-1:0] RESET_VAL = 8'hD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [POL_W-1:0]  pol,
  input  aflags_t           calc,
  input  logic              load,
  input  logic [CCR_W-1:0]  wdata,
  output logic [CCR_W-1:0]  ccr_q
);
  logic [NUM_AFLAGS-1:0] calc_v;
  logic [NUM_AFLAGS-1:0] upd;
  logic [CCR_W-1:0]      ccr_d;

  assign calc_v = calc;

  for (genvar k = 0; k < NUM_AFLAGS; k++) begin : g_flag
    flag_pol_e p;
    logic      cur;
    assign p   = flag_pol_e'(pol[2*k +: 2]);
    assign cur = ccr_q[af_pos(k)];
    assign upd[k] = (p == POL_KEEP) ? cur :
                    (p == POL_CLR)  ? 1'b0 :
                    (p == POL_SET)  ? 1'b1 : calc_v[k];
  end

  always_comb begin
    ccr_d = ccr_q;
    if (load) begin
      ccr_d = wdata;
    end else if (upd_en) begin
      for (int k = 0; k < NUM_AFLAGS; k++) ccr_d[af_pos(k)] = upd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ccr_q <= RESET_VAL;
    else     ccr_q <= ccr_d;
  end

  assert_ctl_bits_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ccr_q[BIT_S]) && $stable(ccr_q[BIT_X]) && $stable(ccr_q[BIT_I])));

  assert_load_copies_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (ccr_q == $past(wdata)));

  assert_keep_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !load && pol[1:0] == POL_KEEP) |=> $stable(ccr_q[BIT_C]));

  assert_clear_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !load && pol[1:0] == POL_CLR) |=> !ccr_q[BIT_C]);

  assert_set_half_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !load && pol[9:8] == POL_SET) |=> ccr_q[BIT_H]);

  assert_idle_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (!upd_en && !load) |=> $stable(ccr_q));
endmodule

// File: rtl/ccbu_branch_eval.sv
module ccbu_branch_eval
  import ccbu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             eval,
  input  logic [3:0]       sel,
  input  logic [CCR_W-1:0] ccr_in,
  output logic             take
);
  // even codes hold the base condition, odd codes its inverse
  logic [7:0] base;
  logic       n_x_v;
  logic       decide;

  always_comb begin
    n_x_v   = ccr_in[BIT_N] ^ ccr_in[BIT_V];
    base[0] = 1'b1;
    base[1] = !ccr_in[BIT_C] && !ccr_in[BIT_Z];
    base[2] = !ccr_in[BIT_C];
    base[3] = !ccr_in[BIT_Z];
    base[4] = !ccr_in[BIT_V];
    base[5] = !ccr_in[BIT_N];
    base[6] = !n_x_v;
    base[7] = !ccr_in[BIT_Z] && !n_x_v;
    decide  = base[sel[3:1]] ^ sel[0];
  end

  always_ff @(posedge clk) begin
    if (rst) take <= 1'b0;
    else     take <= eval && decide;
  end

  assert_always_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (eval && sel == 4'd0) |=> take);

  assert_never_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (eval && sel == 4'd1) |=> !take);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !eval |=> !take);

  assert_equal_uses_z_R9: assert property (@(posedge clk) disable iff (rst)
    (eval && sel == 4'd7) |=> (take == $past(ccr_in[BIT_Z])));
endmodule

// File: rtl/ccr_branch_unit.sv
module ccr_branch_unit
  import ccbu_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter logic [CCR_W-1:0] RESET_CCR = 8'hD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_m,
  input  logic              use_carry,
  input  logic [POL_W-1:0]  flag_pol,
  input  logic              ccr_load,
  input  logic [CCR_W-1:0]  ccr_wdata,
  input  logic              br_eval,
  input  logic [3:0]        br_sel,
  output logic [DATA_W-1:0] result,
  output logic [CCR_W-1:0]  ccr,
  output logic              br_take
);
  logic [DATA_W-1:0] sum;
  aflags_t           calc_flags;
  logic              carry_in;

  assign carry_in = use_carry && ccr[BIT_C];

  ccbu_adder #(.W(DATA_W)) u_adder (
    .a     (opnd_a),
    .m     (opnd_m),
    .cin   (carry_in),
    .sum   (sum),
    .flags (calc_flags)
  );

  ccbu_flag_reg #(.RESET_VAL(RESET_CCR)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .upd_en (op_valid),
    .pol    (flag_pol),
    .calc   (calc_flags),
    .load   (ccr_load),
    .wdata  (ccr_wdata),
    .ccr_q  (ccr)
  );

  ccbu_branch_eval u_branch (
    .clk    (clk),
    .rst    (rst),
    .eval   (br_eval),
    .sel    (br_sel),
    .ccr_in (ccr),
    .take   (br_take)
  );

  always_ff @(posedge clk) begin
    if (rst)           result <= '0;
    else if (op_valid) result <= sum;
  end

  assert_zero_tracks_result_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_load && flag_pol[5:4] == POL_CALC) |=> (ccr[BIT_Z] == (result == '0)));

  assert_neg_tracks_result_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_load && flag_pol[7:6] == POL_CALC) |=> (ccr[BIT_N] == result[DATA_W-1]));

  assert_result_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(result));
endmodule

// File: tb/ccr_branch_unit_tb.sv
module ccr_branch_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] opnd_a = 8'h00;
  logic [7:0] opnd_m = 8'h00;
  logic       use_carry = 1'b0;
  logic [9:0] flag_pol = 10'h000;
  logic       ccr_load = 1'b0;
  logic [7:0] ccr_wdata = 8'h00;
  logic       br_eval = 1'b0;
  logic [3:0] br_sel = 4'h0;
  logic [7:0] result;
  logic [7:0] ccr;
  logic       br_take;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_res;
  logic [7:0] exp_ccr;

  localparam logic [9:0] ALL_CALC = 10'h3FF;

  always #5 clk = ~clk;

  ccr_branch_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opnd_a(opnd_a), .opnd_m(opnd_m),
    .use_carry(use_carry), .flag_pol(flag_pol), .ccr_load(ccr_load),
    .ccr_wdata(ccr_wdata), .br_eval(br_eval), .br_sel(br_sel),
    .result(result), .ccr(ccr), .br_take(br_take)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // independent model of one add step: R2, R3, R4, R5
  task automatic model_op(input logic [7:0] a, input logic [7:0] m,
                          input logic uc, input logic [9:0] pol);
    int cin, tot, lo;
    logic [4:0] calc;
    logic [7:0] s;
    cin = (uc && exp_ccr[0]) ? 1 : 0;
    tot = int'(a) + int'(m) + cin;
    lo  = int'(a & 8'h0F) + int'(m & 8'h0F) + cin;
    s   = tot[7:0];
    calc[0] = (tot > 255);
    calc[1] = (a[7] == m[7]) && (s[7] != a[7]);
    calc[2] = (s == 8'h00);
    calc[3] = s[7];
    calc[4] = (lo > 15);
    exp_res = s;
    for (int k = 0; k < 5; k++) begin
      int pos;
      pos = (k == 4) ? 5 : k;
      case (pol[2*k +: 2])
        2'd0: ;
        2'd1: exp_ccr[pos] = 1'b0;
        2'd2: exp_ccr[pos] = 1'b1;
        default: exp_ccr[pos] = calc[k];
      endcase
    end
  endtask

  function automatic logic cond(input logic [3:0] sel, input logic [7:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (sel)
      4'd0:  cond = 1'b1;
      4'd1:  cond = 1'b0;
      4'd2:  cond = (c == 1'b0) && (z == 1'b0);
      4'd3:  cond = c || z;
      4'd4:  cond = !c;
      4'd5:  cond = c;
      4'd6:  cond = !z;
      4'd7:  cond = z;
      4'd8:  cond = !v;
      4'd9:  cond = v;
      4'd10: cond = !n;
      4'd11: cond = n;
      4'd12: cond = (n == v);
      4'd13: cond = (n != v);
      4'd14: cond = !z && (n == v);
      default: cond = z || (n != v);
    endcase
  endfunction

  task automatic step_op(input logic [7:0] a, input logic [7:0] m,
                         input logic uc, input logic [9:0] pol, input string tag);
    @(negedge clk);
    opnd_a = a; opnd_m = m; use_carry = uc; flag_pol = pol; op_valid = 1'b1;
    model_op(a, m, uc, pol);
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " result R2"}, {24'h0, result}, {24'h0, exp_res});
    chk({tag, " ccr R5"}, {24'h0, ccr}, {24'h0, exp_ccr});
  endtask

  task automatic load_ccr(input logic [7:0] v);
    @(negedge clk);
    ccr_load = 1'b1; ccr_wdata = v;
    @(negedge clk);
    ccr_load = 1'b0;
    exp_ccr = v;
    chk("explicit load R7", {24'h0, ccr}, {24'h0, v});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("reset result R1", {24'h0, result}, 32'h0);
    chk("reset ccr R1", {24'h0, ccr}, 32'hD0);
    chk("reset take R1", {31'h0, br_take}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("after reset ccr R1", {24'h0, ccr}, 32'hD0);
    exp_res = 8'h00; exp_ccr = 8'hD0;
  endtask

  task automatic t_arith;
    step_op(8'hAA, 8'hBC, 1'b0, ALL_CALC, "AA+BC R3 R4");
    chk("AA+BC flags R4", {27'h0, ccr[5], ccr[3:0]}, {27'h0, 1'b1, 4'b0011});
    step_op(8'h7F, 8'h01, 1'b0, ALL_CALC, "7F+01 overflow R3");
    step_op(8'hFF, 8'h01, 1'b0, ALL_CALC, "FF+01 zero carry R3");
    step_op(8'h10, 8'h05, 1'b1, ALL_CALC, "add with carry set R2");
    step_op(8'h80, 8'h80, 1'b0, ALL_CALC, "80+80 R3");
    step_op(8'h20, 8'h30, 1'b1, ALL_CALC, "add with carry clear R2");
    step_op(8'h08, 8'h08, 1'b0, ALL_CALC, "half carry R4");
  endtask

  task automatic t_policy;
    load_ccr(8'h2F);
    step_op(8'h01, 8'h01, 1'b0, 10'b00_00_00_00_01, "clear carry only R5");
    load_ccr(8'h21);
    step_op(8'h00, 8'h00, 1'b0, 10'b00_11_11_01_00, "index-load style R5");
    step_op(8'hFF, 8'hFF, 1'b0, 10'h000, "no-flag op R5");
    step_op(8'h00, 8'h00, 1'b0, 10'b10_01_10_01_10, "mixed set clear R5");
  endtask

  task automatic t_idle;
    logic [7:0] r0, c0;
    step_op(8'h33, 8'h44, 1'b0, ALL_CALC, "prime idle R2");
    r0 = result; c0 = ccr;
    @(negedge clk);
    opnd_a = 8'hFF; opnd_m = 8'h01; flag_pol = 10'b10_10_10_10_10; use_carry = 1'b1;
    repeat (2) @(negedge clk);
    chk("idle result R6", {24'h0, result}, {24'h0, r0});
    chk("idle ccr R6", {24'h0, ccr}, {24'h0, c0});
  endtask

  task automatic t_ctl_bits;
    load_ccr(8'h00);
    step_op(8'h12, 8'h34, 1'b0, 10'b10_10_10_10_10, "set all arith R7");
    chk("ctl bits stay clear R7", {29'h0, ccr[7], ccr[6], ccr[4]}, 32'h0);
    // load wins over a simultaneous flag update; sum still registers
    @(negedge clk);
    op_valid = 1'b1; opnd_a = 8'h05; opnd_m = 8'h06; use_carry = 1'b0; flag_pol = ALL_CALC;
    ccr_load = 1'b1; ccr_wdata = 8'h9A;
    @(negedge clk);
    op_valid = 1'b0; ccr_load = 1'b0;
    chk("load priority R7", {24'h0, ccr}, 32'h9A);
    chk("sum with load R2", {24'h0, result}, 32'h0B);
    exp_ccr = 8'h9A; exp_res = 8'h0B;
  endtask

  task automatic t_branch_all;
    for (int f = 0; f < 16; f++) begin
      load_ccr({4'b0101, f[3:0]});
      for (int s = 0; s < 16; s++) begin
        logic e;
        string tag;
        e = cond(s[3:0], {4'b0101, f[3:0]});
        tag = (s >= 12) ? "signed R10" : ((s == 2 || s == 3) ? "unsigned R11" : "simple R9");
        @(negedge clk);
        br_eval = 1'b1; br_sel = s[3:0];
        @(negedge clk);
        br_eval = 1'b0;
        chk($sformatf("branch %s sel %0d flags %0h", tag, s, f), {31'h0, br_take}, {31'h0, e});
      end
      @(negedge clk);
      chk("no request R8", {31'h0, br_take}, 32'h0);
    end
  endtask

  task automatic t_branch_timing;
    load_ccr(8'h00);
    @(negedge clk);
    op_valid = 1'b1; opnd_a = 8'h00; opnd_m = 8'h00; use_carry = 1'b0; flag_pol = ALL_CALC;
    br_eval = 1'b1; br_sel = 4'd7;
    @(negedge clk);
    op_valid = 1'b0; br_eval = 1'b0;
    chk("decision uses old Z R8", {31'h0, br_take}, 32'h0);
    chk("Z now set R4", {31'h0, ccr[2]}, 32'h1);
    @(negedge clk);
    br_eval = 1'b1; br_sel = 4'd7;
    @(negedge clk);
    br_eval = 1'b0;
    chk("decision sees new Z R8", {31'h0, br_take}, 32'h1);
    @(negedge clk);
    chk("pulse ends R8", {31'h0, br_take}, 32'h0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_arith;
    t_policy;
    t_idle;
    t_ctl_bits;
    t_branch_all;
    t_branch_timing;
    summary;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary;
  end
endmodule